// File: doc/BRIEF.md
# IPv4 Flow Tuple Hash Unit

This block turns the identifying fields of an IPv4 flow into a slot number for a flow-offload table of 4096 entries. Each cycle it may take one tuple: a source address, a destination address, a source transport port and a destination transport port, all qualified by a valid strobe. A fixed number of cycles later it presents an even table index together with a valid flag. It never stalls.

The mixing is a fixed function, not a CRC. The two ports form a 32-bit key. Each key bit chooses the matching bit from one of the two addresses. The chosen word is rotated, then combined by XOR with the key and both addresses. The result is folded to a narrow value and scaled so that the index always lands on an even slot. Fields are taken in host bit order, with bit 31 or bit 15 as the most significant bit, and no bytes are swapped inside the block. Three parameters decide which pipeline boundaries hold a register: after the inputs, between mixing and folding, and on the result. The latency is the number of registers selected.

Top module: `flow_hash_unit`

## Requirements
- R1: The 32-bit key word carries the source port in bits 31:16 and the destination port in bits 15:0.
- R2: A select word takes bit i from the destination address when key bit i is 1, and from the source address when key bit i is 0.
- R3: The mixed word equals key XOR destination address XOR source address XOR (select word rotated left by 8 bit positions).
- R4: The folded value is (mixed word shifted right by 16) XOR (bits 19:0 of the mixed word). The 12-bit index is bits 10:0 of the folded value multiplied by two. An all-zero tuple gives index 0.
- R5: Every valid index has bit 0 equal to 0, so its value lies between 0 and 4094.
- R6: out_valid equals in_valid delayed by LATENCY = REG_IN + REG_MID + REG_OUT cycles (3 by default). The index belongs to the tuple that was accepted LATENCY cycles earlier.
- R7: A new tuple is accepted on every cycle in which in_valid is high, with no back-pressure. Back-to-back tuples and tuples separated by gaps come out in order, and each result is independent of its neighbours.
- R8: rst is synchronous and active high. At the first clock edge with rst high, every pipeline stage is emptied. While rst stays high, out_valid is low on the cycle after each edge, and tuples presented during reset produce no result.
- R9: The function is direction-sensitive. The reverse tuple, with addresses swapped and ports swapped, is hashed by the same rules as any other tuple and generally gives a different index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a tuple for hashing in this cycle |
| in_saddr | input | 32 | Source IPv4 address, host bit order |
| in_daddr | input | 32 | Destination IPv4 address, host bit order |
| in_sport | input | 16 | Source transport port |
| in_dport | input | 16 | Destination transport port |
| out_valid | output | 1 | A result is present |
| out_index | output | 12 | Even table slot, 0 to 4094 |

## Verification
Two events can occur in the same cycle. A new tuple can enter while an older result leaves, and reset can arrive while valid tuples are still inside the pipeline. The stream of tuples is sent back to back with random gaps, so entry and exit coincide on most cycles. A reset is raised in the middle of that stream, with in_valid held high during reset. A model of the expected output is compared with the ports on every cycle. It must show that each result matches the tuple accepted three cycles earlier, and that nothing in flight when reset arrived ever appears at the output.

// File: rtl/fh_pkg.sv
package fh_pkg;

    localparam int ADDR_W      = 32;
    localparam int PORT_W      = 16;
    localparam int KEY_W       = 2 * PORT_W;
    localparam int ROT_AMT     = 8;
    localparam int FOLD_SHIFT  = 16;
    localparam int FOLD_KEEP   = 20;
    localparam int SLOT_BITS   = 11;
    localparam int INDEX_W     = SLOT_BITS + 1;
    localparam int TABLE_DEPTH = 1 << INDEX_W;
    localparam int TUPLE_W     = 2 * ADDR_W + 2 * PORT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] saddr;
        logic [ADDR_W-1:0] daddr;
        logic [PORT_W-1:0] sport;
        logic [PORT_W-1:0] dport;
    } tuple_t;

    typedef logic [KEY_W-1:0]   key_t;
    typedef logic [ADDR_W-1:0]  word_t;
    typedef logic [INDEX_W-1:0] index_t;

    function automatic word_t rotl(input word_t w, input int amt);
        return (w << amt) | (w >> (ADDR_W - amt));
    endfunction

    function automatic index_t fold_to_index(input word_t m);
        word_t upper;
        word_t lower;
        word_t f;
        upper = m >> FOLD_SHIFT;
        lower = m & word_t'((64'd1 << FOLD_KEEP) - 64'd1);
        f     = upper ^ lower;
        return {f[SLOT_BITS-1:0], 1'b0};
    endfunction

endpackage

// File: rtl/fh_pipe_reg.sv
module fh_pipe_reg #(
    parameter int W  = 32,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_valid,
    input  logic [W-1:0] i_data,
    output logic         o_valid,
    output logic [W-1:0] o_data
);

    generate
        if (EN) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    o_valid <= 1'b0;
                    o_data  <= '0;
                end else begin
                    o_valid <= i_valid;
                    o_data  <= i_data;
                end
            end
        end else begin : g_wire
            assign o_valid = i_valid;
            assign o_data  = i_data;
        end
    endgenerate

endmodule

// File: rtl/fh_mix.sv
module fh_mix
    import fh_pkg::*;
(
    input  tuple_t tup,
    output word_t  mixed
);

    key_t  key;
    word_t sel;

    always_comb begin
        key   = {tup.sport, tup.dport};
        sel   = (key & tup.daddr) | (~key & tup.saddr);
        mixed = key ^ tup.daddr ^ tup.saddr ^ rotl(sel, ROT_AMT);
    end

endmodule

// File: rtl/fh_fold.sv
module fh_fold
    import fh_pkg::*;
(
    input  word_t  mixed,
    output index_t index
);

    always_comb begin
        index = fold_to_index(mixed);
    end

endmodule

// File: rtl/flow_hash_unit.sv
module flow_hash_unit
    import fh_pkg::*;
#(
    parameter bit REG_IN  = 1'b1,
    parameter bit REG_MID = 1'b1,
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_saddr,
    input  logic [31:0] in_daddr,
    input  logic [15:0] in_sport,
    input  logic [15:0] in_dport,
    output logic        out_valid,
    output logic [11:0] out_index
);

    localparam int LATENCY = int'(REG_IN) + int'(REG_MID) + int'(REG_OUT);

    tuple_t in_tup;
    tuple_t a_tup;
    logic   a_valid;
    word_t  a_mix;
    word_t  b_mix;
    logic   b_valid;
    index_t b_idx;

    assign in_tup = '{saddr: in_saddr, daddr: in_daddr,
                      sport: in_sport, dport: in_dport};

    fh_pipe_reg #(.W(TUPLE_W), .EN(REG_IN)) u_in_reg (
        .clk     (clk),
        .rst     (rst),
        .i_valid (in_valid),
        .i_data  (in_tup),
        .o_valid (a_valid),
        .o_data  (a_tup)
    );

    fh_mix u_mix (
        .tup   (a_tup),
        .mixed (a_mix)
    );

    fh_pipe_reg #(.W(ADDR_W), .EN(REG_MID)) u_mid_reg (
        .clk     (clk),
        .rst     (rst),
        .i_valid (a_valid),
        .i_data  (a_mix),
        .o_valid (b_valid),
        .o_data  (b_mix)
    );

    fh_fold u_fold (
        .mixed (b_mix),
        .index (b_idx)
    );

    fh_pipe_reg #(.W(INDEX_W), .EN(REG_OUT)) u_out_reg (
        .clk     (clk),
        .rst     (rst),
        .i_valid (b_valid),
        .i_data  (b_idx),
        .o_valid (out_valid),
        .o_data  (out_index)
    );

endmodule

// File: rtl/fh_checker.sv
module fh_checker #(
    parameter int LAT = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_saddr,
    input logic [31:0] in_daddr,
    input logic [15:0] in_sport,
    input logic [15:0] in_dport,
    input logic        out_valid,
    input logic [11:0] out_index
);

    logic [LAT:0] vd;
    logic [LAT:0] zd;

    assign vd[0] = in_valid;
    assign zd[0] = (in_saddr == 32'd0) && (in_daddr == 32'd0) &&
                   (in_sport == 16'd0) && (in_dport == 16'd0);

    generate
        for (genvar g = 1; g <= LAT; g++) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    vd[g] <= 1'b0;
                    zd[g] <= 1'b0;
                end else begin
                    vd[g] <= vd[g-1];
                    zd[g] <= zd[g-1];
                end
            end
        end
    endgenerate

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == vd[LAT]); // R6

    AST_INDEX_EVEN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_index[0] == 1'b0)); // R5

    AST_ZERO_TUPLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zd[LAT]) |-> (out_index == 12'd0)); // R4

    generate
        if (LAT > 0) begin : g_flush
            AST_RESET_FLUSH: assert property (@(posedge clk)
                rst |=> !out_valid); // R8
        end
    endgenerate

endmodule

bind flow_hash_unit fh_checker #(.LAT(LATENCY)) u_fh_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_saddr  (in_saddr),
    .in_daddr  (in_daddr),
    .in_sport  (in_sport),
    .in_dport  (in_dport),
    .out_valid (out_valid),
    .out_index (out_index)
);

// File: tb/flow_hash_unit_bench.sv
module flow_hash_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_saddr = '0;
    logic [31:0] in_daddr = '0;
    logic [15:0] in_sport = '0;
    logic [15:0] in_dport = '0;
    logic        out_valid;
    logic [11:0] out_index;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        bit        v;
        bit [11:0] idx;
        string     tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_hash_unit u_flow_hash_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_saddr  (in_saddr),
        .in_daddr  (in_daddr),
        .in_sport  (in_sport),
        .in_dport  (in_dport),
        .out_valid (out_valid),
        .out_index (out_index)
    );

    // Behavioural expectation, worked bit by bit from the requirements
    function automatic bit [11:0] expect_index(bit [31:0] sa, bit [31:0] da,
                                               bit [15:0] sp, bit [15:0] dp);
        bit [31:0] key;
        bit [31:0] pick;
        bit [31:0] turned;
        bit [31:0] mix;
        bit [31:0] f;
        int        slot;
        key = {sp, dp};                                   // R1
        for (int i = 0; i < 32; i++)
            pick[i] = key[i] ? da[i] : sa[i];             // R2
        for (int i = 0; i < 32; i++)
            turned[(i + 8) % 32] = pick[i];               // R3
        mix  = key ^ da ^ sa ^ turned;
        f    = (mix >> 16) ^ (mix & 32'h000F_FFFF);       // R4
        slot = int'(f % 2048);
        return 12'(slot * 2);
    endfunction

    task automatic compare_now();
        exp_t  e;
        string vtag;
        e = q.pop_front();
        vtag = (e.tag == "R8") ? "R8" : "R6";
        checks++;
        if (out_valid !== e.v) begin
            fails++;
            $display("FAIL %s: out_valid actual %0b expected %0b", vtag, out_valid, e.v);
        end
        if (e.v) begin
            checks++;
            if (out_index !== e.idx) begin
                fails++;
                $display("FAIL %s: out_index actual %0d expected %0d", e.tag, out_index, e.idx);
            end
            checks++;
            if (out_index[0] !== 1'b0 || out_index > 12'd4094) begin
                fails++;
                $display("FAIL R5: out_index actual %0d expected even and <= 4094", out_index);
            end
        end
    endtask

    task automatic step(bit v, bit [31:0] sa, bit [31:0] da,
                        bit [15:0] sp, bit [15:0] dp, string tag, bit r);
        exp_t e;
        @(negedge clk);
        compare_now();
        rst      = r;
        in_valid = v;
        in_saddr = sa;
        in_daddr = da;
        in_sport = sp;
        in_dport = dp;
        e.v   = v && !r;
        e.idx = expect_index(sa, da, sp, dp);
        e.tag = tag;
        q.push_back(e);
        if (r) begin
            foreach (q[k]) begin
                q[k].v   = 1'b0;
                q[k].tag = "R8";
            end
        end
    endtask

    task automatic flow_pair(bit [31:0] a, bit [31:0] b, bit [15:0] pa, bit [15:0] pb);
        step(1'b1, a, b, pa, pb, "R9", 1'b0);
        step(1'b1, b, a, pb, pa, "R9", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        exp_t e;
        for (int i = 0; i < LAT; i++) begin
            e.v = 1'b0; e.idx = '0; e.tag = "R8";
            q.push_back(e);
        end
        repeat (2) @(posedge clk);
        // reset state, with tuples offered during reset
        step(1'b1, 32'h0A00_0001, 32'h0A00_0002, 16'd80, 16'd443, "R8", 1'b1);
        step(1'b1, 32'h0A00_0003, 32'h0A00_0004, 16'd81, 16'd444, "R8", 1'b1);
        // fixed patterns
        step(1'b1, 32'h0, 32'h0, 16'h0, 16'h0, "R4", 1'b0);
        step(1'b1, 32'h0, 32'h0, 16'h1234, 16'h0, "R1", 1'b0);
        step(1'b1, 32'h0, 32'h0, 16'h0, 16'h1234, "R1", 1'b0);
        step(1'b1, 32'hA5A5_5A5A, 32'h3C3C_C3C3, 16'hFFFF, 16'hFFFF, "R2", 1'b0);
        step(1'b1, 32'hA5A5_5A5A, 32'h3C3C_C3C3, 16'h0000, 16'h0000, "R2", 1'b0);
        step(1'b1, 32'hFF00_0000, 32'h0, 16'h0, 16'h0, "R3", 1'b0);
        step(1'b1, 32'h0, 32'h8000_0001, 16'h00F0, 16'h0F00, "R3", 1'b0);
        step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, "R5", 1'b0);
        step(1'b1, 32'h000F_FFFF, 32'h0, 16'h0, 16'h0, "R4", 1'b0);
        step(1'b0, 32'h0, 32'h0, 16'h0, 16'h0, "R6", 1'b0);
        step(1'b0, 32'h0, 32'h0, 16'h0, 16'h0, "R6", 1'b0);
        // both directions of several flows
        flow_pair(32'hC0A8_0105, 32'h5DB8_D822, 16'd51234, 16'd443);
        flow_pair(32'h0A01_0203, 32'h0808_0808, 16'd5353, 16'd53);
        flow_pair(32'hAC10_0001, 32'hAC10_00FE, 16'd1, 16'd65535);
        // random stream, back to back with gaps
        for (int n = 0; n < 300; n++) begin
            bit v;
            v = ($urandom % 4) != 0;
            step(v, $urandom, $urandom, 16'($urandom), 16'($urandom), "R7", 1'b0);
        end
        // reset arriving while results are in flight
        for (int n = 0; n < 4; n++)
            step(1'b1, $urandom, $urandom, 16'($urandom), 16'($urandom), "R7", 1'b0);
        step(1'b1, $urandom, $urandom, 16'($urandom), 16'($urandom), "R8", 1'b1);
        step(1'b1, $urandom, $urandom, 16'($urandom), 16'($urandom), "R8", 1'b1);
        for (int n = 0; n < 6; n++)
            step(1'b1, $urandom, $urandom, 16'($urandom), 16'($urandom), "R7", 1'b0);
        for (int n = 0; n < LAT + 2; n++)
            step(1'b0, 32'h0, 32'h0, 16'h0, 16'h0, "R6", 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule